// File: doc/BRIEF.md
# Shift and Rotate Unit

A purely combinational unit that moves the bits of an N-bit operand by a given distance. One datapath covers six operations: logical shifts in both directions, arithmetic shifts in both directions, and rotates in both directions. It also has a pass-through code.

Each result bit is picked by its own N-input multiplexer, and the shift amount drives that multiplexer's select. The unit is therefore a flat mux array with no sequencing. It is meant to sit inside an execution stage, where the result is consumed in the same cycle that the operands arrive.

The arithmetic left shift is the same as the logical left shift. The rotates feed the bits that leave one end back into the other end.

Top module: `shrot_unit`

## Requirements
- R1: Code 3'b000 (logical left) moves every bit up by `amt_i` places and fills the vacated low positions with 0. For example, 8'h19 shifted by 2 gives 8'h64.
- R2: Code 3'b001 (logical right) moves every bit down by `amt_i` places and fills the vacated high positions with 0. For example, 8'h19 shifted by 2 gives 8'h06.
- R3: Code 3'b010 (arithmetic left) gives exactly the result of code 3'b000 for every operand and amount, zero fill included.
- R4: Code 3'b011 (arithmetic right) moves bits down by `amt_i` places and fills the vacated high positions with copies of the operand's top bit. For example, 8'hC8 shifted by 2 gives 8'hF2.
- R5: Code 3'b100 (rotate left) moves bits up by `amt_i` places, and the bits that leave the top re-enter at the bottom. For example, 8'h19 rotated by 2 gives 8'h64, and 8'hC1 rotated by 2 gives 8'h07.
- R6: Code 3'b101 (rotate right) moves bits down by `amt_i` places, and the bits that leave the bottom re-enter at the top. For example, 8'h19 rotated by 2 gives 8'h46.
- R7: Codes 3'b110 and 3'b111 return the operand unchanged, whatever the amount.
- R8: An amount of 0 returns the operand unchanged for every code.
- R9: The result depends only on the present inputs and settles within the same cycle. There is no register, so all-zero inputs give an all-zero result.
- R10: The width N is a parameter with a default of 8. It must be a power of two of at least 2, and the amount input is $clog2(N) bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_i | input | N | Operand to be shifted or rotated |
| amt_i | input | $clog2(N) | Distance in bit positions |
| op_i | input | 3 | Operation code |
| res_o | output | N | Shifted or rotated result |

## Verification
The unit holds no state, so an error in a tap or a select line shows up in the very cycle the matching operand, amount and code are applied. The error is always a wrong bit in `res_o`. A tap wired to the wrong source position corrupts only the combinations that route through it. For that reason, every code is swept against every amount and every 8-bit operand value, and each combination is compared with a behavioural model. Errors that live at the edges are not missed: wrong fill values, a wrong wrap direction, and a wrong arithmetic fill bit all appear at the boundary amounts 1 and N-1, and those amounts are part of the sweep.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   typedef enum logic [2:0] {
      SR_LSL   = 3'b000,
      SR_LSR   = 3'b001,
      SR_ASL   = 3'b010,
      SR_ASR   = 3'b011,
      SR_ROL   = 3'b100,
      SR_ROR   = 3'b101,
      SR_PASSA = 3'b110,
      SR_PASSB = 3'b111
   } sr_op_e;

endpackage

// File: rtl/shrot_taps.sv
// Builds the N candidate values of one result bit, one candidate per shift amount.
module shrot_taps
   import shrot_pkg::*;
#(
   parameter int N   = 8,
   parameter int BIT = 0
) (
   input  logic [N-1:0] opd_i,
   input  sr_op_e       op_i,
   output logic [N-1:0] taps_o
);

   localparam int TOP = N - 1;

   for (genvar k = 0; k < N; k++) begin : g_tap
      localparam int UP_SRC = BIT - k;       // source bit for a left move
      localparam int DN_SRC = BIT + k;       // source bit for a right move
      localparam int UP_WRP = (BIT - k + N) % N;
      localparam int DN_WRP = (BIT + k) % N;

      logic up_fill0;
      logic dn_fill0;
      logic dn_fills;
      logic pick;

      if (UP_SRC >= 0) begin : g_up_in
         assign up_fill0 = opd_i[UP_SRC];
      end else begin : g_up_out
         assign up_fill0 = 1'b0;
      end

      if (DN_SRC < N) begin : g_dn_in
         assign dn_fill0 = opd_i[DN_SRC];
         assign dn_fills = opd_i[DN_SRC];
      end else begin : g_dn_out
         assign dn_fill0 = 1'b0;
         assign dn_fills = opd_i[TOP];
      end

      always_comb begin
         unique case (op_i)
            SR_LSL, SR_ASL: pick = up_fill0;
            SR_LSR:         pick = dn_fill0;
            SR_ASR:         pick = dn_fills;
            SR_ROL:         pick = opd_i[UP_WRP];
            SR_ROR:         pick = opd_i[DN_WRP];
            default:        pick = opd_i[BIT];
         endcase
      end

      assign taps_o[k] = pick;
   end

endmodule

// File: rtl/shrot_sel.sv
// One N-input multiplexer; the shift amount selects the tap.
module shrot_sel #(
   parameter int N  = 8,
   parameter int AW = 3
) (
   input  logic [N-1:0]  taps_i,
   input  logic [AW-1:0] amt_i,
   output logic          bit_o
);

   assign bit_o = taps_i[amt_i];

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int N = 8,
   localparam int AW = $clog2(N)
) (
   input  logic [N-1:0]  opd_i,
   input  logic [AW-1:0] amt_i,
   input  logic [2:0]    op_i,
   output logic [N-1:0]  res_o
);

   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_width
      $error("shrot_unit: N must be a power of two of at least 2"); // R10
   end

   sr_op_e op_e;
   assign op_e = sr_op_e'(op_i);

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [N-1:0] taps;

      shrot_taps #(.N(N), .BIT(i)) u_taps (
         .opd_i (opd_i),
         .op_i  (op_e),
         .taps_o(taps)
      );

      shrot_sel #(.N(N), .AW(AW)) u_sel (
         .taps_i(taps),
         .amt_i (amt_i),
         .bit_o (res_o[i])
      );
   end

   // Checks on the assembled result against the inputs.
   always_comb begin
      if (amt_i == '0)
         AST_ZERO_AMT_IDENT: assert (res_o == opd_i) else $error("zero amount changed operand"); // R8
      if (op_i[2:1] == 2'b11)
         AST_PASS_CODES: assert (res_o == opd_i) else $error("pass code altered operand"); // R7
      if (op_i == 3'b100 || op_i == 3'b101)
         AST_ROT_KEEPS_ONES: assert ($countones(res_o) == $countones(opd_i)) else $error("rotate lost bits"); // R5
      if ((op_i == 3'b000 || op_i == 3'b010) && amt_i != '0)
         AST_LEFT_ZERO_LSB: assert (res_o[0] == 1'b0) else $error("left shift did not zero fill"); // R3
      if (op_i == 3'b011)
         AST_ASR_SIGN_KEPT: assert (res_o[N-1] == opd_i[N-1]) else $error("sign bit not kept"); // R4
      if (op_i == 3'b001 && amt_i != '0)
         AST_LSR_ZERO_MSB: assert (res_o[N-1] == 1'b0) else $error("right shift did not zero fill"); // R2
   end

endmodule

// File: tb/shrot_unit_test.sv
module shrot_unit_test;

   localparam int N  = 8;
   localparam int AW = $clog2(N);

   logic          clk = 1'b0;
   logic [N-1:0]  opd;
   logic [AW-1:0] amt;
   logic [2:0]    op;
   logic [N-1:0]  res;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   shrot_unit #(.N(N)) uut (
      .opd_i(opd),
      .amt_i(amt),
      .op_i (op),
      .res_o(res)
   );

   // Behavioural reference, written from the requirements.
   function automatic logic [N-1:0] model(logic [N-1:0] a, int s, int code);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         int up = i - s;
         int dn = i + s;
         case (code)
            0, 2: r[i] = (up >= 0) ? a[up] : 1'b0;
            1:    r[i] = (dn < N) ? a[dn] : 1'b0;
            3:    r[i] = (dn < N) ? a[dn] : a[N-1];
            4:    r[i] = a[(up + N) % N];
            5:    r[i] = a[dn % N];
            default: r[i] = a[i];
         endcase
      end
      return r;
   endfunction

   function automatic string tag(int code, int s);
      if (s == 0) return "R8";
      case (code)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(string req, logic [N-1:0] exp);
      checks++;
      if (res !== exp) begin
         errors++;
         $display("FAIL %s: op=%0d amt=%0d opd=%h got %h expected %h",
                  req, op, amt, opd, res, exp);
      end
   endtask

   task automatic apply(logic [N-1:0] a, int s, int code);
      @(posedge clk);
      opd = a;
      amt = AW'(s);
      op  = 3'(code);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000 && !done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      opd = '0;
      amt = '0;
      op  = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9", '0);                 // R9: no stored state, zero in gives zero out

      // Directed examples from the requirements.
      apply(8'h19, 2, 0); check("R1", 8'h64);
      apply(8'h19, 2, 1); check("R2", 8'h06);
      apply(8'h19, 2, 2); check("R3", 8'h64);
      apply(8'hC8, 2, 3); check("R4", 8'hF2);
      apply(8'h19, 2, 4); check("R5", 8'h64);
      apply(8'hC1, 2, 4); check("R5", 8'h07);
      apply(8'h19, 2, 5); check("R6", 8'h46);
      apply(8'hA5, 5, 6); check("R7", 8'hA5);
      apply(8'h3C, 7, 7); check("R7", 8'h3C);
      apply(8'h80, 7, 3); check("R4", 8'hFF);
      apply(8'h01, 7, 5); check("R6", 8'h02);
      apply(8'h5A, 0, 3); check("R8", 8'h5A);

      // R9: the result follows a change of input within the same cycle.
      apply(8'hFF, 1, 1); check("R9", 8'h7F);
      apply(8'hFF, 1, 0); check("R9", 8'hFE);

      // R10: default width; the full amount range 0..N-1 is reachable.
      apply(8'h81, N - 1, 4); check("R10", model(8'h81, N - 1, 4));

      // Exhaustive sweep against the reference model.
      for (int code = 0; code < 8; code++) begin
         for (int s = 0; s < N; s++) begin
            for (int v = 0; v < 256; v++) begin
               apply(N'(v), s, code);
               check(tag(code, s), model(N'(v), s, code));
            end
         end
      end

      done = 1'b1;
      finish_run();
   end

endmodule